// File: doc/BRIEF.md
# Receive-Buffer Flow Control Engine

This block keeps a receive buffer from overrunning by slowing the link partner. It compares the free space reported by the buffer, counted in kilobytes, against programmable watermarks. In full-duplex operation it asks the transmit side to send pause frames. In half-duplex operation it raises a jam-enable window that the transmit side turns into back-pressure jamming for a programmable time.

Pause requests follow a hysteresis scheme. A pause with the maximum time (FFFFh) is requested when free space falls below the high watermark. A release pause (time 0000h) is requested once free space climbs back above the low watermark, and only if the maximum-time pause was actually sent. Software can also force either pause value. The block further keeps track of pause frames received from the partner: a sticky seen flag, and a flag showing whether the partner currently has the block paused.

Top module: `rxbuf_flow_ctrl`

## Requirements
- R1: After reset, `thr_q` reads 38h (high watermark 3 in bits 7:4, low watermark 8 in bits 3:0), `bp_q` reads 37h (back-pressure threshold 3 in bits 7:4, jam code 7 in bits 3:0), `ctl_q` reads 0, and `pause_req`, `jam_en`, `rx_pause_seen` and `paused_now` are low.
- R2: With automatic pausing enabled (`ctl_q` bit 0) and no release pending, free space below the high watermark raises `pause_req` with `pause_time` FFFFh one cycle later.
- R3: A release request (`pause_time` 0000h) is raised when free space is above the low watermark, and only after an automatic FFFFh request has been acknowledged. Without such an acknowledgement, no automatic 0000h request is ever raised.
- R4: With automatic pausing disabled, free-space levels never raise a request.
- R5: Writing 1 to `ctl_wdata` bit 3 forces an FFFFh request, and writing 1 to bit 4 forces a 0000h request. Writing 0 to either bit leaves it unchanged. Each bit reads back in `ctl_q` until its own request is acknowledged. Priority, highest first: forced FFFFh, forced 0000h, automatic.
- R6: `pause_req` and `pause_time` hold steady until `pause_ack`. The request drops in the cycle after the acknowledge.
- R7: Jamming starts when all of these hold in one cycle: half duplex (`full_duplex` low), back pressure enabled (`ctl_q` bit 1), free space below the back-pressure threshold, and the trigger strobe. `jam_en` rises one cycle later.
- R8: In any-packet mode (`ctl_q` bit 2 low), the trigger is `pkt_arrive`. In match-only mode (bit 2 high), the trigger is `da_match`, and `pkt_arrive` alone has no effect.
- R9: No jamming starts in full duplex, with back pressure disabled, or with free space at or above the threshold.
- R10: `jam_en` stays high for exactly D x `CLK_PER_US` cycles. D in microseconds for jam codes 0..8 is 5, 10, 15, 25, 50, 100, 150, 200, 250. For codes 9..15, D is 300 + 50 x (code - 9). A trigger that arrives while jamming does not extend the window.
- R11: `rx_pause_seen` sets in the cycle after `rx_pause_frame` and clears after `stat_rd`. A frame arriving in the same cycle as the read keeps it set.
- R12: `paused_now` follows the most recent received pause frame: high if its time was nonzero, low if it was zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Watermark register write strobe |
| thr_wdata | input | 8 | Watermark write data: high [7:4], low [3:0] |
| bp_we | input | 8 | Back-pressure register write strobe |
| bp_wdata | input | 8 | Back-pressure write data: threshold [7:4], jam code [3:0] |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control bits: 0 auto pause, 1 back pressure, 2 match-only, 3 force FFFFh, 4 force 0000h |
| thr_q | output | 8 | Watermark register readback |
| bp_q | output | 8 | Back-pressure register readback |
| ctl_q | output | 5 | Control register readback, including pending force bits |
| full_duplex | input | 1 | Link duplex: 1 full, 0 half |
| free_kb | input | FREE_W | Free receive space in 1 KB units |
| pkt_arrive | input | 1 | Packet-arrival strobe |
| da_match | input | 1 | Destination-address-match strobe |
| pause_req | output | 1 | Pause frame request |
| pause_time | output | 16 | Pause time carried by the request |
| pause_ack | input | 1 | Pause frame sent |
| jam_en | output | 1 | Back-pressure jam window |
| rx_pause_frame | input | 1 | Pause frame received strobe |
| rx_pause_time | input | 16 | Time field of the received pause frame |
| stat_rd | input | 1 | Status read strobe, clears the seen flag |
| rx_pause_seen | output | 1 | Sticky received-pause flag |
| paused_now | output | 1 | Partner currently has the block paused |

Note: `bp_we` is 1 bit wide; the 8 in its Width column is a typo.

## Verification
Every cycle, the assertions check the following:
- a pending pause request keeps its time until acknowledged;
- no 0000h request appears while no maximum-time pause is outstanding and no forced release is pending;
- no request appears with automatic pausing off and nothing forced;
- jamming never starts in full duplex;
- a received frame always leaves the seen flag set;
- the jam counter stays within its table range.

Only the bench scenarios can show the rest: the exact watermark boundaries over all high-watermark values and free-space levels, the exact jam length for every code, the trigger choice between the two back-pressure modes, the order in which forced requests come out, and the reset values.

// File: rtl/rxbuf_flow_ctrl.sv
module rxbuf_flow_ctrl #(
  parameter int FREE_W     = 5,
  parameter int CLK_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [7:0]        thr_wdata,
  input  logic              bp_we,
  input  logic [7:0]        bp_wdata,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_wdata,
  output logic [7:0]        thr_q,
  output logic [7:0]        bp_q,
  output logic [4:0]        ctl_q,
  input  logic              full_duplex,
  input  logic [FREE_W-1:0] free_kb,
  input  logic              pkt_arrive,
  input  logic              da_match,
  output logic              pause_req,
  output logic [15:0]       pause_time,
  input  logic              pause_ack,
  output logic              jam_en,
  input  logic              rx_pause_frame,
  input  logic [15:0]       rx_pause_time,
  input  logic              stat_rd,
  output logic              rx_pause_seen,
  output logic              paused_now
);

  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int US_W  = 10;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
  localparam logic [1:0] K_ON = 2'd0, K_OFF = 2'd1, K_HI = 2'd2, K_LO = 2'd3;

  logic [3:0] hw_thr, lw_thr, bp_thr, jam_code;
  logic       auto_en, bp_en, match_only, frc_on, frc_off;
  logic       hw_sent;
  logic [1:0] req_kind;
  logic [US_W-1:0]  us_left;
  logic [DIV_W-1:0] div_q;

  assign thr_q = {hw_thr, lw_thr};
  assign bp_q  = {bp_thr, jam_code};
  assign ctl_q = {frc_off, frc_on, match_only, bp_en, auto_en};

  function automatic logic [US_W-1:0] jam_us(input logic [3:0] c);
    case (c)
      4'd0: jam_us = 10'd5;
      4'd1: jam_us = 10'd10;
      4'd2: jam_us = 10'd15;
      4'd3: jam_us = 10'd25;
      4'd4: jam_us = 10'd50;
      4'd5: jam_us = 10'd100;
      4'd6: jam_us = 10'd150;
      4'd7: jam_us = 10'd200;
      4'd8: jam_us = 10'd250;
      default: jam_us = 10'd300 + 10'd50 * {6'd0, c - 4'd9};
    endcase
  endfunction

  wire auto_hi = auto_en && !hw_sent && (32'(free_kb) < 32'(hw_thr));
  wire auto_lo = auto_en &&  hw_sent && (32'(free_kb) > 32'(lw_thr));
  wire any_trig = frc_on || frc_off || auto_hi || auto_lo;
  wire bp_fire = !full_duplex && bp_en && (32'(free_kb) < 32'(bp_thr)) &&
                 (match_only ? da_match : pkt_arrive);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_thr <= 4'd3; lw_thr <= 4'd8; bp_thr <= 4'd3; jam_code <= 4'd7;
      auto_en <= 1'b0; bp_en <= 1'b0; match_only <= 1'b0;
      frc_on <= 1'b0; frc_off <= 1'b0; hw_sent <= 1'b0;
      req_kind <= K_ON; pause_req <= 1'b0; pause_time <= 16'h0000;
    end else begin
      if (thr_we) begin hw_thr <= thr_wdata[7:4]; lw_thr <= thr_wdata[3:0]; end
      if (bp_we)  begin bp_thr <= bp_wdata[7:4];  jam_code <= bp_wdata[3:0]; end
      if (pause_req && pause_ack) begin
        pause_req <= 1'b0;
        case (req_kind)
          K_ON:    frc_on  <= 1'b0;
          K_OFF:   frc_off <= 1'b0;
          K_HI:    hw_sent <= 1'b1;
          default: hw_sent <= 1'b0;
        endcase
      end else if (!pause_req && any_trig) begin
        pause_req <= 1'b1;
        if (frc_on)       begin req_kind <= K_ON;  pause_time <= 16'hFFFF; end
        else if (frc_off) begin req_kind <= K_OFF; pause_time <= 16'h0000; end
        else if (auto_hi) begin req_kind <= K_HI;  pause_time <= 16'hFFFF; end
        else              begin req_kind <= K_LO;  pause_time <= 16'h0000; end
      end
      if (ctl_we) begin
        auto_en    <= ctl_wdata[0];
        bp_en      <= ctl_wdata[1];
        match_only <= ctl_wdata[2];
        if (ctl_wdata[3]) frc_on  <= 1'b1;
        if (ctl_wdata[4]) frc_off <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jam_en <= 1'b0; us_left <= '0; div_q <= '0;
    end else if (!jam_en) begin
      if (bp_fire) begin
        jam_en <= 1'b1; us_left <= jam_us(jam_code); div_q <= '0;
      end
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (us_left == 10'd1) jam_en <= 1'b0;
      else us_left <= us_left - 10'd1;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pause_seen <= 1'b0; paused_now <= 1'b0;
    end else begin
      if (rx_pause_frame) begin
        rx_pause_seen <= 1'b1;
        paused_now    <= (rx_pause_time != 16'h0000);
      end else if (stat_rd) begin
        rx_pause_seen <= 1'b0;
      end
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack) |=> (pause_req && $stable(pause_time)));

  assert_release_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_req && !hw_sent && !frc_off) |=> !(pause_req && pause_time == 16'h0000));

  assert_auto_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_req && !auto_en && !frc_on && !frc_off) |=> !pause_req);

  assert_no_jam_fdx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_en && full_duplex) |=> !jam_en);

  assert_rx_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_frame |=> rx_pause_seen);

  assert_jam_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    us_left <= 10'd600);

endmodule

// File: tb/rxbuf_flow_ctrl_tb.sv
module rxbuf_flow_ctrl_tb_top;
  localparam int CPU = 2;
  localparam int FW  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic thr_we = 0, bp_we = 0, ctl_we = 0;
  logic [7:0] thr_wdata = 0, bp_wdata = 0;
  logic [4:0] ctl_wdata = 0;
  logic [7:0] thr_q, bp_q;
  logic [4:0] ctl_q;
  logic full_duplex = 0;
  logic [FW-1:0] free_kb = 5'd31;
  logic pkt_arrive = 0, da_match = 0, pause_ack = 0;
  logic pause_req, jam_en;
  logic [15:0] pause_time;
  logic rx_pause_frame = 0, stat_rd = 0;
  logic [15:0] rx_pause_time = 0;
  logic rx_pause_seen, paused_now;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  rxbuf_flow_ctrl #(.FREE_W(FW), .CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .bp_we(bp_we), .bp_wdata(bp_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .thr_q(thr_q), .bp_q(bp_q), .ctl_q(ctl_q), .full_duplex(full_duplex),
    .free_kb(free_kb), .pkt_arrive(pkt_arrive), .da_match(da_match),
    .pause_req(pause_req), .pause_time(pause_time), .pause_ack(pause_ack),
    .jam_en(jam_en), .rx_pause_frame(rx_pause_frame), .rx_pause_time(rx_pause_time),
    .stat_rd(stat_rd), .rx_pause_seen(rx_pause_seen), .paused_now(paused_now));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int dur_us(input int c);
    int t [9] = '{5, 10, 15, 25, 50, 100, 150, 200, 250};
    return (c < 9) ? t[c] : 300 + 50 * (c - 9);
  endfunction

  task automatic ack_req();
    pause_ack = 1; step(); pause_ack = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic exp;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 thr_q", thr_q, 8'h38);
    chk("R1 bp_q", bp_q, 8'h37);
    chk("R1 ctl_q", ctl_q, 5'h00);
    chk("R1 outputs", {pause_req, jam_en, rx_pause_seen, paused_now}, 4'b0000);

    ctl_we = 1; ctl_wdata = 5'b00001; step(); ctl_we = 0;
    for (int hw = 0; hw < 16; hw++) begin
      for (int f = 0; f < 21; f++) begin
        thr_we = 1; thr_wdata = {hw[3:0], hw[3:0]}; free_kb = 5'd31; step(); thr_we = 0;
        free_kb = f[FW-1:0]; step();
        exp = (f < hw);
        chk("R2 high-water request", pause_req, exp);
        if (exp) begin
          chk("R2 time FFFF", pause_time, 16'hFFFF);
          free_kb = 5'd31; step();
          chk("R6 hold until ack", {pause_req, pause_time}, {1'b1, 16'hFFFF});
          ack_req();
          chk("R6 drop after ack", pause_req, 1'b0);
          step();
          chk("R3 release after high pause", {pause_req, pause_time}, {1'b1, 16'h0000});
          ack_req();
          chk("R6 release drop", pause_req, 1'b0);
        end else begin
          free_kb = 5'd31; step();
          chk("R3 no release without high pause", pause_req, 1'b0);
        end
      end
    end

    thr_we = 1; thr_wdata = 8'h38; step(); thr_we = 0;
    ctl_we = 1; ctl_wdata = 5'b00000; step(); ctl_we = 0;
    free_kb = 5'd0;
    for (int i = 0; i < 4; i++) begin step(); chk("R4 auto disabled", pause_req, 1'b0); end
    free_kb = 5'd31;

    ctl_we = 1; ctl_wdata = 5'b11000; step(); ctl_we = 0;
    chk("R5 force bits read back", ctl_q, 5'b11000);
    step();
    chk("R5 forced FFFF first", {pause_req, pause_time}, {1'b1, 16'hFFFF});
    ack_req();
    chk("R5 force-on cleared", ctl_q, 5'b10000);
    step();
    chk("R5 forced 0000 next", {pause_req, pause_time}, {1'b1, 16'h0000});
    ack_req();
    chk("R5 force-off cleared", {ctl_q, pause_req}, {5'b00000, 1'b0});
    ctl_we = 1; ctl_wdata = 5'b00000; step(); ctl_we = 0;
    chk("R5 write 0 no request", pause_req, 1'b0);

    bp_we = 1; bp_wdata = 8'h40; step(); bp_we = 0;
    for (int fd = 0; fd < 2; fd++)
      for (int en = 0; en < 2; en++)
        for (int md = 0; md < 2; md++)
          for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++) begin
              full_duplex = fd[0];
              ctl_we = 1; ctl_wdata = {2'b00, md[0], en[0], 1'b0}; step(); ctl_we = 0;
              free_kb = f[FW-1:0];
              pkt_arrive = (s == 0); da_match = (s == 1);
              step();
              pkt_arrive = 0; da_match = 0;
              exp = (fd == 0) && (en == 1) && (f < 4) && ((md == 1) ? (s == 1) : (s == 0));
              if (md == 1) chk("R8 match-only trigger", jam_en, exp);
              else if (fd == 1 || en == 0 || f >= 4) chk("R9 jam blocked", jam_en, exp);
              else chk("R7 any-packet trigger", jam_en, exp);
              cnt = 0;
              while (jam_en && cnt < 100) begin cnt++; step(); end
            end

    full_duplex = 0; free_kb = 5'd0;
    ctl_we = 1; ctl_wdata = 5'b00010; step(); ctl_we = 0;
    for (int c = 0; c < 16; c++) begin
      bp_we = 1; bp_wdata = {4'd4, c[3:0]}; step(); bp_we = 0;
      pkt_arrive = 1; step(); pkt_arrive = 0;
      cnt = 0;
      while (jam_en && cnt < 3000) begin
        cnt++;
        pkt_arrive = (cnt == 3);
        step();
      end
      pkt_arrive = 0;
      chk("R10 jam duration", cnt, dur_us(c) * CPU);
      step();
    end

    rx_pause_frame = 1; rx_pause_time = 16'h0005; step(); rx_pause_frame = 0;
    chk("R11 seen set", rx_pause_seen, 1'b1);
    chk("R12 paused on nonzero", paused_now, 1'b1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R11 cleared on read", rx_pause_seen, 1'b0);
    chk("R12 paused held", paused_now, 1'b1);
    rx_pause_frame = 1; stat_rd = 1; rx_pause_time = 16'h0000; step();
    rx_pause_frame = 0; stat_rd = 0;
    chk("R11 frame beats read", rx_pause_seen, 1'b1);
    chk("R12 unpaused on zero", paused_now, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule